// File: doc/BRIEF.md
# Interrupt Control Register Unit

This unit collects five single-cycle event pulses from neighbouring peripheral logic and presents them to a processor through one 8-bit bus register. The five events are timer A underflow, timer B underflow, time-of-day alarm, serial port full/empty, and an external flag. Each pulse is latched in a status byte whether or not that source is enabled. A hidden enable mask decides which latched sources pull the active-low request line. When any enabled source is latched, the top bit of the status byte reads as 1, so software can poll several such units to find the one that is requesting.

Software changes the mask only through writes with set/clear semantics. Data bit 7 chooses between setting and clearing. Each 1 in bits 6..0 selects the mask bit that is affected. Each 0 leaves the matching mask bit alone. Reading the register returns the status byte. The same read empties the status byte, and so releases the request line. An event that lands in the same cycle as the read is kept for the next read.

Top module: `intc_unit`

## Requirements
- R1: After synchronous reset, irq_n is 1, the status byte is 0x00 and every mask bit is 0. A source that is latched right after reset therefore leaves irq_n at 1.
- R2: A pulse on evt[i] latches status bit i whether or not mask bit i is set. The bit positions are 0 = timer A, 1 = timer B, 2 = alarm, 3 = serial, 4 = flag. Status bits 6..5 are never set.
- R3: While some latched status bit i (i in 0..4) has mask bit i at 1, the read value has bit 7 at 1 and irq_n is 0. Both appear in the cycle after the edge that latches the event.
- R4: A read (sel and rd_stb high) returns {IR, status[6:0]} on rdata in the same cycle. At that clock edge all status bits are cleared, so irq_n returns to 1 and the next read gives 0x00.
- R5: A write with wdata[7] = 1 sets to 1 every mask bit i (0..6) for which wdata[i] = 1.
- R6: A write with wdata[7] = 0 clears to 0 every mask bit i (0..6) for which wdata[i] = 1.
- R7: A mask bit whose wdata bit is 0 keeps its value on a write, for either value of wdata[7].
- R8: A write never changes the status byte. The mask is never visible on rdata.
- R9: An event that coincides with a read is not lost. It is latched after the clear and is reported by the next read.
- R10: IR and irq_n are recomputed every cycle from status AND mask. Enabling a source that is already latched drives irq_n low in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register select for the bus |
| rd_stb | input | 1 | Read strobe, qualified by sel |
| wr_stb | input | 1 | Write strobe, qualified by sel |
| wdata | input | 8 | Write data: bit 7 is set/clear, bits 6..0 select mask bits |
| evt | input | 5 | Event pulses: timer A, timer B, alarm, serial, flag |
| rdata | output | 8 | Status byte with IR in bit 7 during a read, else 0 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Read data is combinational from the stored status, so it is due in the same cycle as the strobe. The monitor samples it at the falling edge of that cycle and compares it with the value that the read task queued.

The effects of an event pulse, a mask write or a read clear are each due one cycle later, after the capturing edge. The bench drives inputs just after a rising edge, holds them for exactly one cycle, and checks irq_n or issues the following read only after that edge. The same-cycle read-plus-event case is checked by two back-to-back reads with separate expected values.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_SRC = 5;
    localparam int SEL_W   = DATA_W - 1;
    localparam int IR_BIT  = DATA_W - 1;

    typedef enum logic [2:0] {
        SRC_TMR_A = 3'd0,
        SRC_TMR_B = 3'd1,
        SRC_TOD   = 3'd2,
        SRC_SER   = 3'd3,
        SRC_FLAG  = 3'd4
    } src_e;

    typedef struct packed {
        logic             set_mode;
        logic [SEL_W-1:0] sel;
    } mask_cmd_t;

    typedef struct packed {
        logic      rd_en;
        logic      wr_en;
        mask_cmd_t cmd;
    } bus_req_t;

    function automatic logic [SEL_W-1:0] mask_update(
        input logic [SEL_W-1:0] cur,
        input mask_cmd_t        c
    );
        return c.set_mode ? (cur | c.sel) : (cur & ~c.sel);
    endfunction

    function automatic logic any_pending(
        input logic [SEL_W-1:0] stat,
        input logic [SEL_W-1:0] mask
    );
        return |(stat[NUM_SRC-1:0] & mask[NUM_SRC-1:0]);
    endfunction

endpackage

// File: rtl/intc_bus_decode.sv
module intc_bus_decode
    import intc_pkg::*;
(
    input  logic              sel,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output bus_req_t          req
);
    always_comb begin
        req.rd_en        = sel & rd_stb;
        req.wr_en        = sel & wr_stb;
        req.cmd.set_mode = wdata[DATA_W-1];
        req.cmd.sel      = wdata[SEL_W-1:0];
    end
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg
    import intc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  mask_cmd_t        cmd,
    output logic [SEL_W-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr_en) begin
            mask_q <= mask_update(mask_q, cmd);
        end
    end
endmodule

// File: rtl/intc_status_reg.sv
module intc_status_reg
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr,
    output logic [SEL_W-1:0]   stat_q
);
    for (genvar i = 0; i < SEL_W; i++) begin : g_bit
        if (i < NUM_SRC) begin : g_src
            always_ff @(posedge clk) begin
                if (rst) begin
                    stat_q[i] <= 1'b0;
                end else begin
                    stat_q[i] <= evt[i] | (stat_q[i] & ~clr);
                end
            end
        end else begin : g_spare
            always_ff @(posedge clk) begin
                if (rst) begin
                    stat_q[i] <= 1'b0;
                end else begin
                    stat_q[i] <= stat_q[i] & ~clr;
                end
            end
        end
    end
endmodule

// File: rtl/intc_req_gen.sv
module intc_req_gen
    import intc_pkg::*;
(
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  stat,
    input  logic [SEL_W-1:0]  mask,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n
);
    logic ir;

    always_comb begin
        ir    = any_pending(stat, mask);
        irq_n = ~ir;
        rdata = rd_en ? {ir, stat} : '0;
    end
endmodule

// File: rtl/intc_unit.sv
module intc_unit
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sel,
    input  logic               rd_stb,
    input  logic               wr_stb,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_SRC-1:0] evt,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_n
);
    bus_req_t         req;
    logic [SEL_W-1:0] mask_w;
    logic [SEL_W-1:0] stat_w;

    intc_bus_decode u_dec (
        .sel    (sel),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .wdata  (wdata),
        .req    (req)
    );

    intc_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (req.wr_en),
        .cmd    (req.cmd),
        .mask_q (mask_w)
    );

    intc_status_reg u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .clr    (req.rd_en),
        .stat_q (stat_w)
    );

    intc_req_gen u_req (
        .rd_en  (req.rd_en),
        .stat   (stat_w),
        .mask   (mask_w),
        .rdata  (rdata),
        .irq_n  (irq_n)
    );
endmodule

// File: rtl/intc_unit_chk.sv
module intc_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       sel,
    input logic       rd_stb,
    input logic       wr_stb,
    input logic [4:0] evt,
    input logic [7:0] rdata,
    input logic       irq_n,
    input logic [6:0] stat_w
);
    // R1
    rst_irq_high_chk: assert property (@(posedge clk) rst |=> irq_n);

    // R2
    evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (evt != 5'd0) |=> ((stat_w[4:0] & $past(evt)) == $past(evt)));

    // R3
    ir_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_stb) |-> (rdata[7] == !irq_n));

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_stb && evt == 5'd0) |=> (stat_w == 7'd0 && irq_n));

    // R8
    wr_keep_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && wr_stb && !rd_stb && evt == 5'd0) |=> $stable(stat_w));

    // R9
    rd_keep_evt_chk: assert property (@(posedge clk) disable iff (rst)
        (sel && rd_stb && evt != 5'd0) |=> (stat_w == {2'b00, $past(evt)}));
endmodule

bind intc_unit intc_unit_chk u_chk (.*);

// File: tb/intc_unit_tb.sv
`timescale 1ns/1ps
module intc_unit_tb;
    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b0;
    logic       rd_stb = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [4:0] evt = 5'd0;
    logic [7:0] rdata;
    logic       irq_n;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    intc_unit u_dut (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .rd_stb (rd_stb),
        .wr_stb (wr_stb),
        .wdata  (wdata),
        .evt    (evt),
        .rdata  (rdata),
        .irq_n  (irq_n)
    );

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [7:0] d);
        sel = 1'b1; wr_stb = 1'b1; wdata = d;
        cycle();
        sel = 1'b0; wr_stb = 1'b0; wdata = 8'h00;
    endtask

    task automatic bus_read(input logic [7:0] exp, input string tag,
                            input logic [4:0] e = 5'd0);
        exp_t it;
        it.val = exp;
        it.tag = tag;
        sb_q.push_back(it);
        sel = 1'b1; rd_stb = 1'b1; evt = e;
        cycle();
        sel = 1'b0; rd_stb = 1'b0; evt = 5'd0;
    endtask

    task automatic pulse(input logic [4:0] e);
        evt = e;
        cycle();
        evt = 5'd0;
    endtask

    task automatic check_irq(input logic exp, input string tag);
        checks++;
        if (irq_n !== exp) begin
            failures++;
            $display("FAIL %s irq_n actual=%b expected=%b", tag, irq_n, exp);
        end
    endtask

    // monitor: compares each read against the queued expectation
    always @(negedge clk) begin
        if (!rst && sel && rd_stb) begin
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL unexpected read rdata actual=%h expected=none", rdata);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                if (rdata !== it.val) begin
                    failures++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata, it.val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) cycle();
        rst = 1'b0;
        cycle();
        check_irq(1'b1, "R1 reset");
        bus_read(8'h00, "R1 reset status");

        // R2: latch with mask all zero
        pulse(5'b00001);
        check_irq(1'b1, "R1 mask zero after reset");
        bus_read(8'h01, "R2 timer A latched");
        bus_read(8'h00, "R4 cleared by read");
        pulse(5'b11111);
        bus_read(8'h1F, "R2 all sources");

        // R5: set mask bit 0
        bus_write(8'h81);
        check_irq(1'b1, "R8 write leaves status empty");
        pulse(5'b00010);
        check_irq(1'b1, "R7 timer B not enabled");
        bus_read(8'h02, "R2 timer B masked");
        pulse(5'b00001);
        check_irq(1'b0, "R3 timer A enabled");
        bus_read(8'h81, "R3 IR in status");
        check_irq(1'b1, "R4 irq released");

        // R5 then R6
        bus_write(8'h9E);
        bus_write(8'h01);
        pulse(5'b00001);
        check_irq(1'b1, "R6 timer A cleared from mask");
        bus_read(8'h01, "R6 status only");
        pulse(5'b00100);
        check_irq(1'b0, "R5 alarm enabled");
        bus_read(8'h84, "R5 alarm with IR");

        // R7: clear only bit 1
        bus_write(8'h02);
        pulse(5'b01000);
        check_irq(1'b0, "R7 serial still enabled");
        bus_read(8'h88, "R7 serial with IR");

        // R8: write disables a latched source; status kept
        pulse(5'b10000);
        check_irq(1'b0, "R3 flag enabled");
        bus_write(8'h10);
        check_irq(1'b1, "R8 mask clear drops irq");
        bus_read(8'h10, "R8 status kept over write");

        // R10: enabling an already latched source
        pulse(5'b10000);
        check_irq(1'b1, "R10 flag latched while masked");
        bus_write(8'h90);
        check_irq(1'b0, "R10 irq right after enable");
        bus_read(8'h90, "R10 status with IR");

        // R9: event together with read (mask now bits 2,3,4)
        pulse(5'b00100);
        bus_read(8'h84, "R9 read while timer B fires", 5'b00010);
        check_irq(1'b1, "R9 timer B masked after read");
        bus_read(8'h02, "R9 coincident event kept");
        bus_read(8'h00, "R4 empty after second read");

        pulse(5'b00010);
        bus_write(8'h82);
        check_irq(1'b0, "R10 timer B enabled late");
        bus_read(8'h82, "R10 timer B with IR");
        check_irq(1'b1, "R4 final release");

        cycle();
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule